// File: doc/BRIEF.md
# SDRAM Manual Initialization Command Issuer

This block lets software walk an SDRAM device through its power-up sequence one command at a time. Software writes a small control register that holds a master enable and three arm bits, one each for precharge-all (PALL), auto-refresh (REF) and mode-register-set (MRS). It then performs a dummy host write to any address in the SDRAM window. That write is only a trigger: its address and data are thrown away. On the trigger the block drives exactly one SDRAM command on the chip-select, RAS, CAS, WE, bank and address pins. In every other cycle it holds the device in deselect.

No timing parameters are applied. Software spaces the commands and covers the power-up wait with its own idle time. The arm bits stay set, so repeated dummy writes repeat the same command. Because of this, sequences such as PALL, REF, REF, MRS or PALL, MRS, REF, REF can be built in any order.

Top module: `sdram_init_cmd_issuer`

## Requirements
- R1: After synchronous reset, the pins idle: sd_cs_n, sd_ras_n, sd_cas_n and sd_we_n are 1, and sd_addr and sd_ba are 0. The enable bit and all arm bits are cleared.
- R2: The control register is written when ctl_we is 1. Its fields are bit 4 enable, bit 2 MRS arm, bit 1 PALL arm and bit 0 REF arm. A trigger is a cycle with host_wr=1 and (host_addr & WIN_MASK) == WIN_BASE while the block is enabled and at least one arm bit is set. The command appears on the pins in the cycle after the trigger cycle and lasts exactly one cycle.
- R3: PALL drives cs_n=0, ras_n=0, cas_n=1, we_n=0, with sd_addr holding only bit 10 set and sd_ba=0.
- R4: REF drives cs_n=0, ras_n=0, cas_n=0, we_n=1, with sd_addr=0 and sd_ba=0.
- R5: MRS drives cs_n=0, ras_n=0, cas_n=0, we_n=0, with sd_addr equal to the mode register (written by mode_we from mode_wdata) and sd_ba=0.
- R6: When several arm bits are set at a trigger, only one command is issued. PALL wins over REF, and REF wins over MRS.
- R7: With the enable bit at 0, or with no arm bit set, a host write produces no command, and the pins stay idle.
- R8: A host write whose address lies outside the window produces no command.
- R9: A trigger in a cycle in which a command is already on the pins is dropped. Two commands are always separated by at least one idle cycle.
- R10: The arm bits persist until the control register is rewritten, so each further trigger reissues the same command.
- R11: In every cycle without a command, the pins show cs_n, ras_n, cas_n and we_n at 1, with sd_addr and sd_ba at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM-side clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data (enable, arm bits) |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | ADDR_W | Mode value driven during MRS |
| host_wr | input | 1 | Host memory-write strobe |
| host_addr | input | HADDR_W | Host write address |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |

## Verification
A register write takes effect at the clock edge that ends its cycle, and a trigger may follow in the very next cycle. A command is due on the pins exactly one cycle after its trigger cycle, and the idle state is due in the cycle after that. The bench drives every input at the falling edge. It samples the pins at the next falling edge to check the command, and at the one after to check the return to idle. This places each sample half a cycle after the rising edge that updated the registered outputs. A trigger held high for three cycles is sampled in each cycle to show the command, the dropped trigger and the reissued command.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PALL = 2'd1,
    CMD_REF  = 2'd2,
    CMD_MRS  = 2'd3
  } init_cmd_e;

  localparam int CTL_EN_BIT   = 4;
  localparam int CTL_MRS_BIT  = 2;
  localparam int CTL_PALL_BIT = 1;
  localparam int CTL_REF_BIT  = 0;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_strobe_t;

  function automatic sd_strobe_t strobes_for(init_cmd_e c);
    sd_strobe_t s;
    case (c)
      CMD_PALL: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF:  s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS:  s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  s = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/init_ctl_regs.sv
module init_ctl_regs #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              mode_we,
  input  logic [ADDR_W-1:0] mode_wdata,
  output logic              en,
  output logic              arm_pall,
  output logic              arm_ref,
  output logic              arm_mrs,
  output logic [ADDR_W-1:0] mode_val
);
  import sdram_init_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      arm_pall <= 1'b0;
      arm_ref  <= 1'b0;
      arm_mrs  <= 1'b0;
    end else if (ctl_we) begin
      en       <= ctl_wdata[CTL_EN_BIT];
      arm_pall <= ctl_wdata[CTL_PALL_BIT];
      arm_ref  <= ctl_wdata[CTL_REF_BIT];
      arm_mrs  <= ctl_wdata[CTL_MRS_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_val <= '0;
    else if (mode_we) mode_val <= mode_wdata;
  end

  // R10
  arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable({en, arm_pall, arm_ref, arm_mrs}));

endmodule

// File: rtl/init_cmd_select.sv
module init_cmd_select #(
  parameter int                  HADDR_W  = 24,
  parameter logic [HADDR_W-1:0]  WIN_BASE = 24'h200000,
  parameter logic [HADDR_W-1:0]  WIN_MASK = 24'hE00000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           host_wr,
  input  logic [HADDR_W-1:0]             host_addr,
  input  logic                           en,
  input  logic                           arm_pall,
  input  logic                           arm_ref,
  input  logic                           arm_mrs,
  input  logic                           busy,
  output sdram_init_pkg::init_cmd_e      cmd_sel
);
  import sdram_init_pkg::*;

  logic win_hit;
  logic fire;

  assign win_hit = ((host_addr & WIN_MASK) == WIN_BASE);
  assign fire    = host_wr && win_hit && en && !busy;

  always_comb begin
    cmd_sel = CMD_NONE;
    if (fire) begin
      if (arm_pall)     cmd_sel = CMD_PALL;
      else if (arm_ref) cmd_sel = CMD_REF;
      else if (arm_mrs) cmd_sel = CMD_MRS;
    end
  end

  // R6
  pall_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_sel != CMD_NONE && arm_pall) |-> cmd_sel == CMD_PALL);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> cmd_sel == CMD_NONE);

endmodule

// File: rtl/init_pin_drive.sv
module init_pin_drive #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  sdram_init_pkg::init_cmd_e cmd_sel,
  input  logic [ADDR_W-1:0]         mode_val,
  output logic                      sd_cs_n,
  output logic                      sd_ras_n,
  output logic                      sd_cas_n,
  output logic                      sd_we_n,
  output logic [BA_W-1:0]           sd_ba,
  output logic [ADDR_W-1:0]         sd_addr,
  output logic                      busy
);
  import sdram_init_pkg::*;

  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << AP_BIT;

  sd_strobe_t        nxt_s;
  logic [ADDR_W-1:0] nxt_addr;

  always_comb begin
    nxt_s = strobes_for(cmd_sel);
    case (cmd_sel)
      CMD_PALL: nxt_addr = PALL_ADDR;
      CMD_MRS:  nxt_addr = mode_val;
      default:  nxt_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_cs_n  <= 1'b1;
      sd_ras_n <= 1'b1;
      sd_cas_n <= 1'b1;
      sd_we_n  <= 1'b1;
      sd_ba    <= '0;
      sd_addr  <= '0;
    end else begin
      sd_cs_n  <= nxt_s.cs_n;
      sd_ras_n <= nxt_s.ras_n;
      sd_cas_n <= nxt_s.cas_n;
      sd_we_n  <= nxt_s.we_n;
      sd_ba    <= '0;
      sd_addr  <= nxt_addr;
    end
  end

  assign busy = !sd_cs_n;

  // R9
  one_cycle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n |=> sd_cs_n);

  // R11
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    sd_cs_n |-> (sd_ras_n && sd_cas_n && sd_we_n && sd_addr == '0));

  // R3
  pall_ap_chk: assert property (@(posedge clk) disable iff (rst)
    (!sd_cs_n && sd_cas_n) |-> (!sd_we_n && sd_addr[AP_BIT]));

endmodule

// File: rtl/sdram_init_cmd_issuer.sv
module sdram_init_cmd_issuer #(
  parameter int                 ADDR_W   = 13,
  parameter int                 BA_W     = 2,
  parameter int                 AP_BIT   = 10,
  parameter int                 HADDR_W  = 24,
  parameter logic [HADDR_W-1:0] WIN_BASE = 24'h200000,
  parameter logic [HADDR_W-1:0] WIN_MASK = 24'hE00000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic [7:0]         ctl_wdata,
  input  logic               mode_we,
  input  logic [ADDR_W-1:0]  mode_wdata,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [BA_W-1:0]    sd_ba,
  output logic [ADDR_W-1:0]  sd_addr
);
  import sdram_init_pkg::*;

  logic              en, arm_pall, arm_ref, arm_mrs, busy;
  logic [ADDR_W-1:0] mode_val;
  init_cmd_e         cmd_sel;

  init_ctl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .en(en), .arm_pall(arm_pall), .arm_ref(arm_ref), .arm_mrs(arm_mrs),
    .mode_val(mode_val)
  );

  init_cmd_select #(.HADDR_W(HADDR_W), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)) u_sel (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_addr(host_addr),
    .en(en), .arm_pall(arm_pall), .arm_ref(arm_ref), .arm_mrs(arm_mrs),
    .busy(busy), .cmd_sel(cmd_sel)
  );

  init_pin_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_drv (
    .clk(clk), .rst(rst),
    .cmd_sel(cmd_sel), .mode_val(mode_val),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .busy(busy)
  );

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> sd_cs_n);

  // R8
  window_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && ((host_addr & WIN_MASK) != WIN_BASE)) |=> sd_cs_n);

  // R2
  cmd_needs_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    !host_wr |=> sd_cs_n);

endmodule

// File: tb/sdram_init_cmd_issuer_tb.sv
module sdram_init_cmd_issuer_tb;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int HW     = 24;
  localparam logic [HW-1:0] BASE = 24'h200000;
  localparam logic [HW-1:0] MASK = 24'hE00000;

  logic clk = 1'b0;
  logic rst;
  logic ctl_we, mode_we, host_wr;
  logic [7:0] ctl_wdata;
  logic [ADDR_W-1:0] mode_wdata;
  logic [HW-1:0] host_addr;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BA_W-1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_init_cmd_issuer u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .host_wr(host_wr), .host_addr(host_addr),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  localparam logic [3+BA_W+ADDR_W:0] IDLE = {4'b1111, {BA_W{1'b0}}, {ADDR_W{1'b0}}};

  function automatic logic [3+BA_W+ADDR_W:0] expect_for(logic [7:0] c, logic [ADDR_W-1:0] m);
    if (!c[4])     return IDLE;
    if (c[1])      return {4'b0010, {BA_W{1'b0}}, ADDR_W'(1) << 10};
    if (c[0])      return {4'b0001, {BA_W{1'b0}}, {ADDR_W{1'b0}}};
    if (c[2])      return {4'b0000, {BA_W{1'b0}}, m};
    return IDLE;
  endfunction

  task automatic check(string tag, logic [3+BA_W+ADDR_W:0] exp);
    logic [3+BA_W+ADDR_W:0] act;
    act = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_mode(logic [ADDR_W-1:0] v);
    mode_we = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic trig(string tag, logic [HW-1:0] a, logic [3+BA_W+ADDR_W:0] exp);
    host_wr = 1'b1; host_addr = a;
    @(negedge clk);
    host_wr = 1'b0;
    check(tag, exp);
    @(negedge clk);
    check({tag, " idle after"}, IDLE);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] mv;
    rst = 1'b1; ctl_we = 0; mode_we = 0; host_wr = 0;
    ctl_wdata = 0; mode_wdata = 0; host_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset idle", IDLE);
    // R1: registers cleared, so a window write right after reset issues nothing
    trig("R1 cleared regs", BASE, IDLE);

    // R2 R3 R4 R5 R6 R7: every enable/arm combination
    for (int v = 0; v < 32; v++) begin
      mv = ADDR_W'(v * 229 + 17);
      wr_mode(mv);
      wr_ctl(8'(v));
      trig("R2 R6 R7 sweep", BASE | HW'(v * 4099), expect_for(8'(v), mv));
    end

    // R8: outside window
    wr_ctl(8'h12);
    trig("R8 miss low", 24'h000100, IDLE);
    trig("R8 miss high", 24'hE00000, IDLE);
    trig("R8 miss near", 24'h400000, IDLE);
    trig("R3 hit top", 24'h3FFFFF, expect_for(8'h12, '0));

    // R10: arm persists across triggers
    wr_ctl(8'h11);
    for (int k = 0; k < 3; k++) trig("R10 repeat REF", BASE + HW'(k), expect_for(8'h11, '0));

    // R9: trigger held three cycles -> command, dropped, command
    host_wr = 1'b1; host_addr = BASE;
    @(negedge clk); check("R9 first", expect_for(8'h11, '0));
    @(negedge clk); check("R9 dropped", IDLE);
    @(negedge clk); host_wr = 1'b0; check("R9 third", expect_for(8'h11, '0));
    @(negedge clk); check("R9 R11 idle", IDLE);

    // R5: ordered sequence PALL, MRS, REF, REF
    wr_mode(13'h0032);
    wr_ctl(8'h12); trig("R3 seq PALL", BASE, expect_for(8'h12, '0));
    wr_ctl(8'h14); trig("R5 seq MRS", BASE, expect_for(8'h14, 13'h0032));
    wr_ctl(8'h11); trig("R4 seq REF", BASE, expect_for(8'h11, '0));
    trig("R4 seq REF2", BASE, expect_for(8'h11, '0));

    // R7: disable clears triggering even with arms written
    wr_ctl(8'h07); trig("R7 disabled", BASE, IDLE);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule